// File: doc/BRIEF.md
# Single-Lane Flash Command Engine

This block runs one short serial-flash transaction, started by software, over a single-lane SPI link in clock mode 0. Software first loads a 32-bit command address and up to eight bytes of outgoing data into holding registers. It then writes one control word that packs the whole command: an opcode byte, an optional address of one to four bytes, an optional run of dummy clocks, optional outgoing data and optional incoming data. Setting the execute bit in that same word starts the transaction. Software polls the in-progress bit and then collects up to eight received bytes from two 32-bit result registers.

Inside the block, a phase sequencer turns the command into a stream of shift items, each holding a byte and a bit count. It hands them to a bit shifter over a valid/ready channel. The shifter accepts a new item only while it is idle, so the sequencer holds each item until ready is high. It then waits for the shifter's completion pulse before it presents the next one. Chip select stays low from the cycle after the start until the last bit has finished.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high and the serial clock is low. The control, read-low and read-high registers all read zero.
- R2: A control write with bit 0 set, made while idle, starts a command. Bit 1 of the control register reads 1 from the next cycle until the command ends, and chip select is low for the whole command. When the command ends, bit 1 reads 0 and chip select is high again.
- R3: The opcode in control bits 31:24 is always sent first, most significant bit first.
- R4: When control bit 19 is set, the address follows the opcode. It is 1 to 4 bytes long (control bits 17:16 hold the count minus one). It is taken from the low bytes of the address register and sent most significant byte first.
- R5: Control bits 11:7 give a number of dummy clocks, 0 to 31, sent after the address with the data line low. A value of 0 sends none.
- R6: When control bit 15 is set, 1 to 8 write bytes follow the dummy clocks. Control bits 14:12 hold the count minus one. Byte k is taken from bits 8k+7:8k of the 64-bit value formed by write-high:write-low.
- R7: When control bit 23 is set, 1 to 8 bytes are received last. Control bits 22:20 hold the count minus one, and each byte is sampled most significant bit first on the rising clock edge. Byte k lands in bits 8k+7:8k of read-high:read-low. All other read bytes are cleared to zero at the start of every command.
- R8: Phases are never reordered, and a disabled phase sends no clocks. A command therefore sends exactly 8 + 8·address bytes + dummy + 8·write bytes + 8·read bytes clock pulses.
- R9: While a command is in progress, writes to the control, address and write-data registers are ignored. This includes a second execute request. The running command's bit stream is unchanged, and the registers read back their earlier values.
- R10: The serial clock idles low. Each high phase lasts exactly HALF_DIV clock cycles. The data output never changes while the serial clock is high.
- R11: Register indices are 0 control, 1 address, 2 write-low, 3 write-high, 4 read-low, 5 read-high. The control register reads back its fields, bit 0 always reads 0, and bits 18 and 6:2 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A corrupted phase or byte index inside the sequencer shows up as a wrong bit on the data output. The scoreboard sees it at the very next rising serial clock edge, or as a missing or extra clock by the time chip select rises. A wrong read byte index or a missed clear shows in the result registers as soon as the in-progress bit drops. A busy flag that fails to block register writes changes the opcode or address bits of the running command, and it also shows in the control and address readback immediately after completion.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  localparam int REG_AW     = 3;
  localparam int BYTE_W     = 8;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W     = DATA_BYTES * BYTE_W;
  localparam int IDX_W      = $clog2(DATA_BYTES);
  localparam int BITS_W     = $clog2(BYTE_W + 1);

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_ADDR = 3'd1;
  localparam logic [REG_AW-1:0] RA_WLO  = 3'd2;
  localparam logic [REG_AW-1:0] RA_WHI  = 3'd3;
  localparam logic [REG_AW-1:0] RA_RLO  = 3'd4;
  localparam logic [REG_AW-1:0] RA_RHI  = 3'd5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADR, PH_DUM, PH_WR, PH_RD, PH_FIN
  } phase_t;

  typedef struct packed {
    logic [7:0] opcode;
    logic       rd_en;
    logic [2:0] rd_cnt;
    logic       adr_en;
    logic [1:0] adr_cnt;
    logic       wr_en;
    logic [2:0] wr_cnt;
    logic [4:0] dummy;
  } cmd_cfg_t;

  // Control word layout that software composes; field positions are fixed.
  function automatic logic [31:0] pack_ctrl(cmd_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[31:24] = c.opcode;
    w[23]    = c.rd_en;
    w[22:20] = c.rd_cnt;
    w[19]    = c.adr_en;
    w[17:16] = c.adr_cnt;
    w[15]    = c.wr_en;
    w[14:12] = c.wr_cnt;
    w[11:7]  = c.dummy;
    return w;
  endfunction

  // First enabled phase strictly after p, in fixed order.
  function automatic phase_t next_phase(phase_t p, cmd_cfg_t c);
    phase_t n;
    n = PH_FIN;
    if (p < PH_RD  && c.rd_en)         n = PH_RD;
    if (p < PH_WR  && c.wr_en)         n = PH_WR;
    if (p < PH_DUM && c.dummy != 5'd0) n = PH_DUM;
    if (p < PH_ADR && c.adr_en)        n = PH_ADR;
    return n;
  endfunction

endpackage

// File: rtl/flash_cmd_shifter.sv
`timescale 1ns/1ps
module flash_cmd_shifter
  import flash_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              item_valid,
  output logic              item_ready,
  input  logic [BYTE_W-1:0] item_data,
  input  logic [BITS_W-1:0] item_bits,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] CNT_END = CW'(HALF_DIV - 1);

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_t;

  sh_state_t         st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] rx;
  logic [BITS_W-1:0] left;
  logic              sclk_q;
  logic              mosi_q;
  logic              done_q;

  assign item_ready = (st == SH_IDLE);
  assign done       = done_q;
  assign rx_byte    = rx;
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SH_IDLE;
      cnt    <= '0;
      sr     <= '0;
      rx     <= '0;
      left   <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        SH_IDLE: begin
          if (item_valid) begin
            sr     <= item_data;
            mosi_q <= item_data[BYTE_W-1];
            left   <= item_bits;
            cnt    <= '0;
            st     <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (cnt == CNT_END) begin
            cnt    <= '0;
            sclk_q <= 1'b1;
            rx     <= {rx[BYTE_W-2:0], miso};
            st     <= SH_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SH_HIGH: begin
          if (cnt == CNT_END) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
            if (left == BITS_W'(1)) begin
              st     <= SH_IDLE;
              done_q <= 1'b1;
              mosi_q <= 1'b0;
            end else begin
              left   <= left - 1'b1;
              sr     <= {sr[BYTE_W-2:0], 1'b0};
              mosi_q <= sr[BYTE_W-2];
              st     <= SH_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_cfg_t          cfg,
  input  logic [31:0]       cmd_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              item_valid,
  input  logic              item_ready,
  output logic [BYTE_W-1:0] item_data,
  output logic [BITS_W-1:0] item_bits,
  input  logic              done,
  output logic              busy,
  output logic              cs_n,
  output logic              rd_load,
  output logic [IDX_W-1:0]  rd_idx
);

  phase_t           ph;
  phase_t           nxt;
  logic [IDX_W-1:0] idx;
  logic [4:0]       dum_left;
  logic [3:0]       dbits;
  logic [1:0]       asel;
  logic             wait_q;
  logic             last;

  assign nxt   = next_phase(ph, cfg);
  assign dbits = (dum_left >= 5'd8) ? 4'd8 : dum_left[3:0];
  assign asel  = cfg.adr_cnt - idx[1:0];

  always_comb begin
    item_data = '0;
    item_bits = BITS_W'(BYTE_W);
    last      = 1'b1;
    unique case (ph)
      PH_OPC: item_data = cfg.opcode;
      PH_ADR: begin
        item_data = cmd_addr[{asel, 3'b000} +: BYTE_W];
        last      = (idx[1:0] == cfg.adr_cnt);
      end
      PH_DUM: begin
        item_bits = BITS_W'(dbits);
        last      = (dum_left <= 5'd8);
      end
      PH_WR: begin
        item_data = wdata[{idx, 3'b000} +: BYTE_W];
        last      = (idx == cfg.wr_cnt);
      end
      PH_RD: last = (idx == cfg.rd_cnt);
      default: ;
    endcase
  end

  assign item_valid = (ph != PH_IDLE) && (ph != PH_FIN) && !wait_q;
  assign busy       = (ph != PH_IDLE);
  assign cs_n       = (ph == PH_IDLE);
  assign rd_load    = done && (ph == PH_RD);
  assign rd_idx     = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      idx      <= '0;
      dum_left <= '0;
      wait_q   <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph     <= PH_OPC;
            idx    <= '0;
            wait_q <= 1'b0;
          end
        end
        PH_FIN: ph <= PH_IDLE;
        default: begin
          if (item_valid && item_ready) wait_q <= 1'b1;
          if (done) begin
            wait_q <= 1'b0;
            if (ph == PH_DUM) dum_left <= dum_left - {1'b0, dbits};
            if (last) begin
              ph  <= nxt;
              idx <= '0;
              if (nxt == PH_DUM) dum_left <= cfg.dummy;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_regs.sv
`timescale 1ns/1ps
module flash_cmd_regs
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output cmd_cfg_t          cfg,
  output logic [31:0]       cmd_addr,
  output logic [DATA_W-1:0] wdata,
  output logic              start
);

  cmd_cfg_t          ctrl_q;
  logic [31:0]       addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              wr_ok;

  assign wr_ok    = reg_wr && !busy;
  assign start    = wr_ok && (reg_addr == RA_CTRL) && reg_wdata[0];
  assign cfg      = ctrl_q;
  assign cmd_addr = addr_q;
  assign wdata    = wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (wr_ok) begin
      unique case (reg_addr)
        RA_CTRL: begin
          ctrl_q.opcode  <= reg_wdata[31:24];
          ctrl_q.rd_en   <= reg_wdata[23];
          ctrl_q.rd_cnt  <= reg_wdata[22:20];
          ctrl_q.adr_en  <= reg_wdata[19];
          ctrl_q.adr_cnt <= reg_wdata[17:16];
          ctrl_q.wr_en   <= reg_wdata[15];
          ctrl_q.wr_cnt  <= reg_wdata[14:12];
          ctrl_q.dummy   <= reg_wdata[11:7];
        end
        RA_ADDR: addr_q <= reg_wdata;
        RA_WLO:  wdat_q[31:0]  <= reg_wdata;
        RA_WHI:  wdat_q[63:32] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (start) begin
      rdat_q <= '0;
    end else if (rd_load) begin
      rdat_q[{rd_idx, 3'b000} +: BYTE_W] <= rd_byte;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = pack_ctrl(ctrl_q) | {30'd0, busy, 1'b0};
      RA_ADDR: reg_rdata = addr_q;
      RA_WLO:  reg_rdata = wdat_q[31:0];
      RA_WHI:  reg_rdata = wdat_q[63:32];
      RA_RLO:  reg_rdata = rdat_q[31:0];
      RA_RHI:  reg_rdata = rdat_q[63:32];
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  cmd_cfg_t          cfg;
  logic [31:0]       cmd_addr;
  logic [DATA_W-1:0] wdata;
  logic              start;
  logic              busy;
  logic              item_valid;
  logic              item_ready;
  logic [BYTE_W-1:0] item_data;
  logic [BITS_W-1:0] item_bits;
  logic              sh_done;
  logic [BYTE_W-1:0] sh_rx;
  logic              rd_load;
  logic [IDX_W-1:0]  rd_idx;

  flash_cmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .rd_load   (rd_load),
    .rd_idx    (rd_idx),
    .rd_byte   (sh_rx),
    .cfg       (cfg),
    .cmd_addr  (cmd_addr),
    .wdata     (wdata),
    .start     (start)
  );

  flash_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg        (cfg),
    .cmd_addr   (cmd_addr),
    .wdata      (wdata),
    .item_valid (item_valid),
    .item_ready (item_ready),
    .item_data  (item_data),
    .item_bits  (item_bits),
    .done       (sh_done),
    .busy       (busy),
    .cs_n       (spi_cs_n),
    .rd_load    (rd_load),
    .rd_idx     (rd_idx)
  );

  flash_cmd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .item_valid (item_valid),
    .item_ready (item_ready),
    .item_data  (item_data),
    .item_bits  (item_bits),
    .done       (sh_done),
    .rx_byte    (sh_rx),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .miso       (spi_miso)
  );

endmodule

// File: rtl/flash_cmd_engine_checker.sv
`timescale 1ns/1ps
module flash_cmd_engine_checker
  import flash_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy,
  input cmd_cfg_t    cfg,
  input logic        spi_cs_n,
  input logic        spi_sclk,
  input logic        spi_mosi
);

  logic [15:0] high_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) high_len <= '0;
    else        high_len <= spi_sclk ? high_len + 1'b1 : 16'd0;
  end

  // R2: a command only begins after a control write carrying the execute bit
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == RA_CTRL && reg_wdata[0]));

  // R2: serial clock is low whenever the command ends
  assert_end_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !spi_sclk);

  // R9: control writes while busy leave the latched command untouched
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == RA_CTRL) |=> $stable(cfg));

  // R10: data line is held through each high phase
  assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R10: clock idles low while deselected
  assert_idle_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R10: each high phase lasts exactly HALF_DIV cycles
  assert_high_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> (high_len == 16'(HALF_DIV)));

endmodule

bind flash_cmd_engine flash_cmd_engine_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (busy),
  .cfg       (cfg),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi)
);

// File: tb/flash_cmd_engine_bench.sv
`timescale 1ns/1ps
module flash_cmd_engine_bench;

  localparam int HALF = 2;
  localparam logic [31:0] CTRL_MASK = 32'hFFFB_FF80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_engine #(.HALF_DIV(HALF)) u_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 0;

  // scoreboard state
  bit          exp_bits[$];
  int          bit_cnt = 0;
  int          pre_bits = 0, rd_bits = 0;
  int          e_adr = 0, e_dum = 0, e_wr = 0;
  logic [63:0] slave_rd = '0;
  int          r10_viol = 0;
  realtime     t_rise = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_byte(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) exp_bits.push_back(b[i]);
  endtask

  function automatic string tag_of(int b);
    if (b < 8)     return "R3";
    if (b < e_adr) return "R4";
    if (b < e_dum) return "R5";
    if (b < e_wr)  return "R6";
    return "R7";
  endfunction

  // monitor: compares each transmitted bit against the expected queue
  initial begin
    forever begin
      @(posedge spi_sclk or negedge spi_cs_n);
      if (spi_sclk) begin
        #1;
        if (exp_bits.size() == 0) begin
          check(1'b0, "R8", "extra clock pulse", 64'(bit_cnt), 64'(pre_bits + rd_bits));
        end else begin
          bit e;
          e = exp_bits.pop_front();
          check(spi_mosi == e, tag_of(bit_cnt), $sformatf("mosi bit %0d", bit_cnt),
                64'(spi_mosi), 64'(e));
        end
        bit_cnt++;
      end else begin
        bit_cnt = 0;
      end
    end
  end

  // flash model: drives read bits after each falling clock edge
  initial begin
    forever begin
      @(negedge spi_sclk or negedge spi_cs_n);
      #1;
      begin
        int j;
        j = bit_cnt - pre_bits;
        if (j >= 0 && j < rd_bits) spi_miso = slave_rd[8*(j/8) + 7 - (j%8)];
        else spi_miso = 1'b0;
      end
    end
  end

  // timing monitor for R10
  always @(spi_mosi) if (spi_sclk) r10_viol++;
  always @(posedge spi_sclk) t_rise = $realtime;
  always @(negedge spi_sclk) if ($realtime - t_rise != HALF * 5.0) r10_viol++;

  task automatic run_cmd(logic [7:0] op, bit aen, int acnt, int dum, bit wen, int wcnt,
                         bit ren, int rcnt, logic [31:0] addr, logic [63:0] w64,
                         logic [63:0] r64, bit poke);
    logic [31:0] ctrl, rd;
    logic [63:0] exp_rd;
    int guard;
    ctrl = {op, ren, 3'(rcnt - 1), aen, 1'b0, 2'(acnt - 1), wen, 3'(wcnt - 1),
            5'(dum), 7'b0000001};
    exp_bits.delete();
    push_byte(op, 8);
    if (aen) for (int k = acnt - 1; k >= 0; k--) push_byte(addr[8*k +: 8], 8);
    for (int k = 0; k < dum; k++) exp_bits.push_back(1'b0);
    if (wen) for (int k = 0; k < wcnt; k++) push_byte(w64[8*k +: 8], 8);
    if (ren) for (int k = 0; k < rcnt * 8; k++) exp_bits.push_back(1'b0);
    e_adr    = 8 + (aen ? acnt * 8 : 0);
    e_dum    = e_adr + dum;
    e_wr     = e_dum + (wen ? wcnt * 8 : 0);
    pre_bits = e_wr;
    rd_bits  = ren ? rcnt * 8 : 0;
    slave_rd = r64;
    reg_write(3'd1, addr);
    reg_write(3'd2, w64[31:0]);
    reg_write(3'd3, w64[63:32]);
    reg_write(3'd0, ctrl);
    reg_read(3'd0, rd);
    check(rd[1] == 1'b1, "R2", "busy right after start", 64'(rd[1]), 64'd1);
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1'b0, "R2", "cs_n during command", 64'(spi_cs_n), 64'd0);
    if (poke) begin
      reg_write(3'd0, 32'hD8FF_FFFF);
      reg_write(3'd1, 32'hFFFF_FFFF);
      reg_write(3'd2, 32'h5A5A_5A5A);
    end
    guard = 0;
    do begin
      reg_read(3'd0, rd);
      guard++;
    end while (rd[1] && guard < 20000);
    check(rd[1] == 1'b0, "R2", "busy clears", 64'(rd[1]), 64'd0);
    check(spi_cs_n == 1'b1, "R2", "cs_n after command", 64'(spi_cs_n), 64'd1);
    check(exp_bits.size() == 0, "R8", "missing clock pulses", 64'(exp_bits.size()), 64'd0);
    exp_rd = '0;
    if (ren) for (int k = 0; k < rcnt; k++) exp_rd[8*k +: 8] = r64[8*k +: 8];
    reg_read(3'd4, rd);
    check(rd == exp_rd[31:0], "R7", "read-low", 64'(rd), 64'(exp_rd[31:0]));
    reg_read(3'd5, rd);
    check(rd == exp_rd[63:32], "R7", "read-high", 64'(rd), 64'(exp_rd[63:32]));
    if (poke) begin
      reg_read(3'd0, rd);
      check(rd == (ctrl & CTRL_MASK), "R9", "control kept", 64'(rd), 64'(ctrl & CTRL_MASK));
      reg_read(3'd1, rd);
      check(rd == addr, "R9", "address kept", 64'(rd), 64'(addr));
      reg_read(3'd2, rd);
      check(rd == w64[31:0], "R9", "write-low kept", 64'(rd), 64'(w64[31:0]));
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "WATCHDOG", "run timed out", 64'd0, 64'd1);
    finish_sim();
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1", "cs_n reset", 64'(spi_cs_n), 64'd1);
    check(spi_sclk == 1'b0, "R1", "sclk reset", 64'(spi_sclk), 64'd0);
    reg_read(3'd0, rd); check(rd == 32'd0, "R1", "control reset", 64'(rd), 64'd0);
    reg_read(3'd4, rd); check(rd == 32'd0, "R1", "read-low reset", 64'(rd), 64'd0);
    reg_read(3'd5, rd); check(rd == 32'd0, "R1", "read-high reset", 64'(rd), 64'd0);

    // R11 readback without execute
    reg_write(3'd0, 32'hFFFF_FFFE);
    reg_read(3'd0, rd);
    check(rd == 32'hFFFB_FF80, "R11", "control readback", 64'(rd), 64'hFFFB_FF80);
    check(spi_cs_n == 1'b1, "R11", "no start without bit 0", 64'(spi_cs_n), 64'd1);
    reg_write(3'd3, 32'hCAFE_0123);
    reg_read(3'd3, rd);
    check(rd == 32'hCAFE_0123, "R11", "write-high readback", 64'(rd), 64'hCAFE_0123);

    // R3 opcode only
    run_cmd(8'h06, 0, 1, 0, 0, 1, 0, 1, 32'h0, 64'h0, 64'h0, 0);
    // R7 read three bytes
    run_cmd(8'h9F, 0, 1, 0, 0, 1, 1, 3, 32'h0, 64'h0, 64'h1122_3344_55C2_EF20, 0);
    // R4 R6 three address bytes, two write bytes
    run_cmd(8'h02, 1, 3, 0, 1, 2, 0, 1, 32'hAB12_3456, 64'h0000_0000_0000_A55A, 64'h0, 0);
    // R4 R5 R7 four address bytes, 8 dummy, eight read bytes
    run_cmd(8'hEC, 1, 4, 8, 0, 1, 1, 8, 32'h8765_4321, 64'h0, 64'hF0E1_D2C3_B4A5_9687, 0);
    // R8 every phase, partial dummy run, eight write bytes
    run_cmd(8'h5A, 1, 1, 5, 1, 8, 1, 1, 32'h0000_00C3, 64'h0102_0408_1020_4080, 64'h0000_0000_0000_0096, 0);
    // R5 maximum dummy, two address bytes; R7 clears earlier read data
    run_cmd(8'h3C, 1, 2, 31, 0, 1, 0, 1, 32'h0000_BEEF, 64'h0, 64'h0, 0);
    // R9 writes while busy are ignored
    run_cmd(8'h0B, 1, 3, 8, 0, 1, 1, 4, 32'h0012_3456, 64'h0000_0000_7777_7777, 64'h0000_0000_DEAD_BEEF, 1);

    check(r10_viol == 0, "R10", "clock timing violations", 64'(r10_viol), 64'd0);
    check(spi_sclk == 1'b0, "R10", "clock idles low", 64'(spi_sclk), 64'd0);
    finish_sim();
  end

endmodule